// File: doc/BRIEF.md
# Pipelined Instruction Class Control

This block is the control spine of a five-stage in-order processor pipeline. The instruction sitting in the decode stage (stage 2) is presented on `instr_i`. At each clock edge a compact slot is captured from it: the opcode, the destination register index and the low count field. That slot then moves through one pipeline register per downstream stage. Each stage runs its own decode on the slot it currently holds, so every control output belongs to the instruction in that stage and never to a newer one.

Stage 3 drives the ALU operand selection and function. Stage 4 drives the data-memory read and write strobes. Stage 5 drives the register-file write enable and the destination index. The datapath, the register file, the memories and any hazard handling sit outside the block. A bubble input replaces the decode-stage instruction with a no-op, which is how the surrounding logic stalls or flushes.

Top module: `instr_class_ctl`

## Requirements
- R1: A synchronous active-high reset fills every stage with a no-op. After the first clock edge with reset high, all stage 3, 4 and 5 outputs are zero.
- R2: Instruction fields: the opcode is bits 31..27, the destination index is bits 26..22 and the count field is bits 4..0. The opcode values are nop 0, ld 1, ldr 2, st 3, str 4, la 5, lar 6, br 8, brl 9, add 12, addi 13, sub 14, neg 15, and 20, andi 21, or 22, ori 23, not 24, shr 26, shra 27, shl 28, shc 29. Every other value behaves as a no-op.
- R3: `s3_alu_en` is high for the ALU class (add, addi, sub, neg, and, andi, or, ori, not, shr, shra, shl, shc) and for the address-forming class (ld, ldr, st, str, la, lar). `s3_alu_fn` is add 0, sub 1, neg 2, and 3, or 4, not 5, shr 6, shra 7, shl 8, shc 9. Address forming uses 0. The function is 0 when `s3_alu_en` is low.
- R4: `s3_b_imm` (second operand from the immediate) is high for addi, andi, ori and all six load/store/load-address opcodes. For the four shifts it is high only when the count field is nonzero.
- R5: `s3_a_pc` (first operand from the program counter) is high only for the PC-relative forms ldr, str and lar.
- R6: `s4_mem_rd` is high only for ld and ldr. `s4_mem_wr` is high only for st and str. la and lar strobe neither, and the two strobes are never high together.
- R7: `s5_reg_we` is high for ld, ldr, la, lar, brl and the ALU class. `s5_dst_idx` is then the destination field; it is 0 when `s5_reg_we` is low.
- R8: An instruction present on `instr_i` before edge k drives the stage-3 outputs after edge k, stage 4 after edge k+1 and stage 5 after edge k+2. Each stage decodes its own held copy, so three different instructions drive the three stages at once.
- R9: With `bubble_i` high, the instruction on `instr_i` is ignored and a no-op enters stage 3. It then yields all-zero outputs in stages 3, 4 and 5 in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction currently in the decode stage |
| bubble_i | input | 1 | Insert a no-op in place of `instr_i` |
| s3_alu_en | output | 1 | Stage 3 uses the ALU |
| s3_a_pc | output | 1 | Stage 3 first operand is the program counter |
| s3_b_imm | output | 1 | Stage 3 second operand is the immediate |
| s3_alu_fn | output | 4 | Stage 3 ALU function code |
| s4_mem_rd | output | 1 | Stage 4 data-memory read strobe |
| s4_mem_wr | output | 1 | Stage 4 data-memory write strobe |
| s5_reg_we | output | 1 | Stage 5 register-file write enable |
| s5_dst_idx | output | 5 | Stage 5 destination register index |

## Verification
The case of interest is a store reaching its stage-4 write strobe in the same cycle that an older load or ALU instruction drives the stage-5 register write. A newer address computation is in stage 3 at that moment. The bench provokes this by streaming every opcode back to back, with shift counts both zero and nonzero, and with bubbles dropped in while a store sits on `instr_i`. Each cycle it compares all three stages against a reference decode of its own input history, shifted by one, two and three edges.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 5;
    localparam int IDX_W   = 5;
    localparam int CNT_W   = 5;
    localparam int FN_W    = 4;
    localparam int OPC_LSB = 27;
    localparam int IDX_LSB = 22;
    localparam int CNT_LSB = 0;
    localparam int STAGES  = 3;   // stages 3, 4 and 5 after decode

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 5'd0,
        OP_LD   = 5'd1,
        OP_LDR  = 5'd2,
        OP_ST   = 5'd3,
        OP_STR  = 5'd4,
        OP_LA   = 5'd5,
        OP_LAR  = 5'd6,
        OP_BR   = 5'd8,
        OP_BRL  = 5'd9,
        OP_ADD  = 5'd12,
        OP_ADDI = 5'd13,
        OP_SUB  = 5'd14,
        OP_NEG  = 5'd15,
        OP_AND  = 5'd20,
        OP_ANDI = 5'd21,
        OP_OR   = 5'd22,
        OP_ORI  = 5'd23,
        OP_NOT  = 5'd24,
        OP_SHR  = 5'd26,
        OP_SHRA = 5'd27,
        OP_SHL  = 5'd28,
        OP_SHC  = 5'd29
    } opc_e;

    typedef enum logic [FN_W-1:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_NEG  = 4'd2,
        FN_AND  = 4'd3,
        FN_OR   = 4'd4,
        FN_NOT  = 4'd5,
        FN_SHR  = 4'd6,
        FN_SHRA = 4'd7,
        FN_SHL  = 4'd8,
        FN_SHC  = 4'd9
    } alu_fn_e;

    // One pipeline slot: just what later stages need to re-decode.
    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [IDX_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    localparam slot_t SLOT_NOP = slot_t'('0);

    function automatic logic op_is_shift(input logic [OPC_W-1:0] op);
        return (op == OP_SHR) || (op == OP_SHRA) || (op == OP_SHL) || (op == OP_SHC);
    endfunction

    function automatic logic op_is_alu(input logic [OPC_W-1:0] op);
        logic r;
        case (op)
            OP_ADD, OP_ADDI, OP_SUB, OP_NEG,
            OP_AND, OP_ANDI, OP_OR, OP_ORI, OP_NOT: r = 1'b1;
            default:                                r = op_is_shift(op);
        endcase
        return r;
    endfunction

    function automatic logic op_is_load(input logic [OPC_W-1:0] op);
        return (op == OP_LD) || (op == OP_LDR);
    endfunction

    function automatic logic op_is_store(input logic [OPC_W-1:0] op);
        return (op == OP_ST) || (op == OP_STR);
    endfunction

    function automatic logic op_is_ladr(input logic [OPC_W-1:0] op);
        return (op == OP_LA) || (op == OP_LAR);
    endfunction

    function automatic logic op_is_mem_class(input logic [OPC_W-1:0] op);
        return op_is_load(op) || op_is_store(op) || op_is_ladr(op);
    endfunction

    function automatic logic op_is_rel(input logic [OPC_W-1:0] op);
        return (op == OP_LDR) || (op == OP_STR) || (op == OP_LAR);
    endfunction

    function automatic logic op_writes_reg(input logic [OPC_W-1:0] op);
        return op_is_load(op) || op_is_ladr(op) || (op == OP_BRL) || op_is_alu(op);
    endfunction

    function automatic logic op_takes_imm(input logic [OPC_W-1:0] op,
                                          input logic [CNT_W-1:0] cnt);
        logic r;
        case (op)
            OP_ADDI, OP_ANDI, OP_ORI: r = 1'b1;
            default: r = op_is_mem_class(op) || (op_is_shift(op) && (cnt != '0));
        endcase
        return r;
    endfunction

    function automatic alu_fn_e op_alu_fn(input logic [OPC_W-1:0] op);
        alu_fn_e f;
        case (op)
            OP_SUB:          f = FN_SUB;
            OP_NEG:          f = FN_NEG;
            OP_AND, OP_ANDI: f = FN_AND;
            OP_OR,  OP_ORI:  f = FN_OR;
            OP_NOT:          f = FN_NOT;
            OP_SHR:          f = FN_SHR;
            OP_SHRA:         f = FN_SHRA;
            OP_SHL:          f = FN_SHL;
            OP_SHC:          f = FN_SHC;
            default:         f = FN_ADD;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/ctl_stage_reg.sv
module ctl_stage_reg
    import ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t d,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= SLOT_NOP;
        else     q <= d;
    end
endmodule

// File: rtl/ctl_alu_stage.sv
module ctl_alu_stage
    import ctl_pkg::*;
(
    input  slot_t           slot,
    output logic            alu_en,
    output logic            a_pc,
    output logic            b_imm,
    output logic [FN_W-1:0] fn
);
    logic unused_rd;
    assign unused_rd = ^slot.rd;

    always_comb begin
        alu_en = op_is_alu(slot.opc) || op_is_mem_class(slot.opc);
        a_pc   = op_is_rel(slot.opc);
        b_imm  = op_takes_imm(slot.opc, slot.cnt);
        fn     = alu_en ? op_alu_fn(slot.opc) : FN_ADD;
    end
endmodule

// File: rtl/ctl_mem_stage.sv
module ctl_mem_stage
    import ctl_pkg::*;
(
    input  slot_t slot,
    output logic  rd_stb,
    output logic  wr_stb
);
    logic unused_fields;
    assign unused_fields = ^{slot.rd, slot.cnt};

    always_comb begin
        rd_stb = op_is_load(slot.opc);
        wr_stb = op_is_store(slot.opc);
    end
endmodule

// File: rtl/ctl_wb_stage.sv
module ctl_wb_stage
    import ctl_pkg::*;
(
    input  slot_t             slot,
    output logic              we,
    output logic [IDX_W-1:0]  idx
);
    logic unused_cnt;
    assign unused_cnt = ^slot.cnt;

    always_comb begin
        we  = op_writes_reg(slot.opc);
        idx = we ? slot.rd : '0;
    end
endmodule

// File: rtl/instr_class_ctl.sv
module instr_class_ctl
    import ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               bubble_i,
    output logic               s3_alu_en,
    output logic               s3_a_pc,
    output logic               s3_b_imm,
    output logic [FN_W-1:0]    s3_alu_fn,
    output logic               s4_mem_rd,
    output logic               s4_mem_wr,
    output logic               s5_reg_we,
    output logic [IDX_W-1:0]   s5_dst_idx
);
    slot_t s2_slot;
    slot_t pipe [1:STAGES];

    logic unused_mid;
    assign unused_mid = ^instr_i[IDX_LSB-1:CNT_LSB+CNT_W];

    always_comb begin
        if (bubble_i) begin
            s2_slot = SLOT_NOP;
        end else begin
            s2_slot.opc = instr_i[OPC_LSB +: OPC_W];
            s2_slot.rd  = instr_i[IDX_LSB +: IDX_W];
            s2_slot.cnt = instr_i[CNT_LSB +: CNT_W];
        end
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        if (i == 1) begin : g_first
            ctl_stage_reg u_reg (.clk(clk), .rst(rst), .d(s2_slot),   .q(pipe[i]));
        end else begin : g_next
            ctl_stage_reg u_reg (.clk(clk), .rst(rst), .d(pipe[i-1]), .q(pipe[i]));
        end
    end

    ctl_alu_stage u_s3 (
        .slot   (pipe[1]),
        .alu_en (s3_alu_en),
        .a_pc   (s3_a_pc),
        .b_imm  (s3_b_imm),
        .fn     (s3_alu_fn)
    );

    ctl_mem_stage u_s4 (
        .slot   (pipe[2]),
        .rd_stb (s4_mem_rd),
        .wr_stb (s4_mem_wr)
    );

    ctl_wb_stage u_s5 (
        .slot   (pipe[STAGES]),
        .we     (s5_reg_we),
        .idx    (s5_dst_idx)
    );

    // Assertions
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!s3_alu_en && !s4_mem_rd && !s4_mem_wr && !s5_reg_we));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(s4_mem_rd && s4_mem_wr));

    assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
        s4_mem_wr |=> !s5_reg_we);

    assert_load_writes_R7: assert property (@(posedge clk) disable iff (rst)
        s4_mem_rd |=> s5_reg_we);

    assert_mem_follows_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (s4_mem_rd || s4_mem_wr) |->
            $past(s3_alu_en && s3_b_imm && (s3_alu_fn == FN_ADD)));

    assert_bubble_zero_R9: assert property (@(posedge clk) disable iff (rst)
        bubble_i |=> (!s3_alu_en && !s3_a_pc && !s3_b_imm && (s3_alu_fn == '0)));

endmodule

// File: tb/instr_class_ctl_tb.sv
module instr_class_ctl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr_i;
    logic        bubble_i;
    logic        s3_alu_en, s3_a_pc, s3_b_imm;
    logic [3:0]  s3_alu_fn;
    logic        s4_mem_rd, s4_mem_wr;
    logic        s5_reg_we;
    logic [4:0]  s5_dst_idx;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] h3, h4, h5;   // instruction now in stage 3, 4, 5

    always #5 clk = ~clk;

    instr_class_ctl u_dut (
        .clk(clk), .rst(rst), .instr_i(instr_i), .bubble_i(bubble_i),
        .s3_alu_en(s3_alu_en), .s3_a_pc(s3_a_pc), .s3_b_imm(s3_b_imm),
        .s3_alu_fn(s3_alu_fn), .s4_mem_rd(s4_mem_rd), .s4_mem_wr(s4_mem_wr),
        .s5_reg_we(s5_reg_we), .s5_dst_idx(s5_dst_idx)
    );

    // Reference for stage 3: {alu_en, a_pc, b_imm, fn[3:0]}
    function automatic logic [6:0] ref3(input logic [31:0] ins);
        logic [4:0] op = ins[31:27];
        logic       sc = (ins[4:0] != 5'd0);
        case (op)
            5'd1, 5'd3, 5'd5: return 7'b101_0000;
            5'd2, 5'd4, 5'd6: return 7'b111_0000;
            5'd12: return {3'b100, 4'd0};
            5'd13: return {3'b101, 4'd0};
            5'd14: return {3'b100, 4'd1};
            5'd15: return {3'b100, 4'd2};
            5'd20: return {3'b100, 4'd3};
            5'd21: return {3'b101, 4'd3};
            5'd22: return {3'b100, 4'd4};
            5'd23: return {3'b101, 4'd4};
            5'd24: return {3'b100, 4'd5};
            5'd26: return {2'b10, sc, 4'd6};
            5'd27: return {2'b10, sc, 4'd7};
            5'd28: return {2'b10, sc, 4'd8};
            5'd29: return {2'b10, sc, 4'd9};
            default: return 7'd0;
        endcase
    endfunction

    // Reference for stage 4: {rd, wr}
    function automatic logic [1:0] ref4(input logic [31:0] ins);
        logic [4:0] op = ins[31:27];
        return {(op == 5'd1 || op == 5'd2), (op == 5'd3 || op == 5'd4)};
    endfunction

    // Reference for stage 5: {we, idx[4:0]}
    function automatic logic [5:0] ref5(input logic [31:0] ins);
        logic [4:0] op = ins[31:27];
        logic we;
        case (op)
            5'd1, 5'd2, 5'd5, 5'd6, 5'd9,
            5'd12, 5'd13, 5'd14, 5'd15,
            5'd20, 5'd21, 5'd22, 5'd23, 5'd24,
            5'd26, 5'd27, 5'd28, 5'd29: we = 1'b1;
            default: we = 1'b0;
        endcase
        return {we, we ? ins[26:22] : 5'd0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string note);
        chk({"R3 R4 R5 R8 stage3 ", note},
            {25'd0, s3_alu_en, s3_a_pc, s3_b_imm, s3_alu_fn}, {25'd0, ref3(h3)});
        chk({"R6 R8 stage4 ", note}, {30'd0, s4_mem_rd, s4_mem_wr}, {30'd0, ref4(h4)});
        chk({"R7 R8 stage5 ", note}, {26'd0, s5_reg_we, s5_dst_idx}, {26'd0, ref5(h5)});
    endtask

    // Apply one decode-stage input, advance one edge, then compare.
    task automatic step(input logic [31:0] ins, input logic bub, input string note);
        instr_i  = ins;
        bubble_i = bub;
        @(posedge clk);
        h5 = h4;
        h4 = h3;
        h3 = bub ? 32'd0 : ins;
        @(negedge clk);
        check_all(note);
    endtask

    function automatic logic [31:0] mk(input int op, input int rd, input int cnt);
        return {op[4:0], rd[4:0], 17'h15a5a, cnt[4:0]};
    endfunction

    initial begin
        rst = 1'b1; instr_i = mk(12, 3, 0); bubble_i = 1'b0;
        h3 = '0; h4 = '0; h5 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 after reset");
        rst = 1'b0;

        // R2: every opcode value, shift count zero and nonzero, varying rd
        for (int op = 0; op < 32; op++) begin
            for (int c = 0; c < 2; c++) begin
                step(mk(op, (op * 7 + c * 11) % 32, c ? ((op % 31) + 1) : 0), 1'b0, "R2 sweep");
            end
        end

        // R9: bubble with a store and a load waiting on the input
        step(mk(3, 9, 4), 1'b1, "R9 bubble over st");
        step(mk(1, 10, 0), 1'b1, "R9 bubble over ld");
        step(mk(28, 11, 0), 1'b0, "R4 shl count zero");
        step(mk(28, 12, 5), 1'b0, "R4 shl count nonzero");
        step(mk(4, 13, 1), 1'b0, "R5 str");
        step(mk(1, 14, 0), 1'b0, "R6 ld after str");
        step(mk(9, 15, 0), 1'b0, "R7 brl");
        step(mk(5, 16, 0), 1'b1, "R9 bubble over la");
        step(mk(0, 0, 0), 1'b0, "R8 drain");
        step(mk(0, 0, 0), 1'b0, "R8 drain");

        // Mixed bubble pattern over the full opcode range
        for (int k = 0; k < 40; k++) begin
            step(mk((k * 13) % 32, (k * 5) % 32, k % 3), (k % 4) == 1, "R9 mixed");
        end

        // R1: reset with a full pipeline
        step(mk(1, 20, 0), 1'b0, "R1 prefill");
        step(mk(3, 21, 0), 1'b0, "R1 prefill");
        instr_i = mk(13, 22, 0);
        rst = 1'b1;
        @(posedge clk);
        h3 = '0; h4 = '0; h5 = '0;
        @(negedge clk);
        check_all("R1 mid-run reset");
        rst = 1'b0;
        step(mk(13, 22, 0), 1'b0, "R1 resume");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule